// File: doc/BRIEF.md
# Trace Memory Read Window

This block sits between a 16-bit register bus and a trace memory whose entries are 64 bits wide. Software reads the memory through one register location, one 16-bit piece per access. A read pointer made of an entry index and a word index selects the piece to return. The pointer moves forward by one piece on each accepted read. The highest 16 bits of an entry are returned first. After the fourth piece the word index returns to zero and the entry index moves to the next entry. The entry index wraps to zero after the last entry.

A small two-state lock machine guards the window. **CLOSED** is the state after reset. It is entered through transition *ARM_LOCK* whenever the armed input is high. **OPEN** is entered from CLOSED through transition *UNLOCK*, taken on an aligned word write made while disarmed. That write also returns the pointer to entry 0, piece 0, and it does not change the stored data. A read is accepted only when all of these hold: the lock is OPEN, the part is not secured, the debugger is not armed, at least one trace-source enable is high, and the access is an aligned word. Any other read returns zero and leaves the pointer unchanged. Clocked storage holds the trace data. Reset does not clear it. A test port writes entries directly into that storage.

Top module: `trace_window`

## Requirements
- R1: After reset the lock is CLOSED and the pointer is at entry 0, piece 0, so every read returns 0 until an unlock write is made.
- R2: An accepted read returns the pieces of an entry in the order bits 63:48, 47:32, 31:16, 15:0. The data appears combinationally during the read strobe.
- R3: The pointer moves forward by exactly one piece on each accepted read and otherwise holds. After piece 3 it moves to piece 0 of the next entry.
- R4: After piece 3 of entry DEPTH-1, the next accepted read returns piece 0 of entry 0.
- R5: A byte read (bus_word=0) returns 0 and does not move the pointer.
- R6: A misaligned read (bus_odd=1) returns 0 and does not move the pointer.
- R7: While armed is high, reads return 0 and the lock goes to CLOSED. The lock stays CLOSED after armed falls, until an unlock write is made.
- R8: While secured is high, reads return 0 and the pointer does not move.
- R9: While every bit of src_en is 0, reads return 0 and the pointer does not move.
- R10: A write with bus_word=1 and bus_odd=0 made while armed is low sets the lock to OPEN, returns the pointer to entry 0, piece 0, and leaves the stored data unchanged.
- R11: A byte write, a misaligned write, or any write made while armed has no effect: the lock stays CLOSED.
- R12: Reset does not change the stored entries. After reset an unlock write followed by a read returns the data loaded before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the lock and the pointer |
| bus_rd | input | 1 | Read strobe to the window |
| bus_wr | input | 1 | Write strobe to the window |
| bus_word | input | 1 | Access size: 1 = 16-bit word, 0 = byte |
| bus_odd | input | 1 | Low address bit: 1 = misaligned |
| armed | input | 1 | Debugger armed status |
| secured | input | 1 | Part secured status |
| src_en | input | SRC_N | Trace-source enables |
| tp_we | input | 1 | Test port: write one entry into storage |
| tp_addr | input | $clog2(DEPTH) | Test port: entry index |
| tp_data | input | ENTRY_W | Test port: entry value |
| rd_data | output | BUS_W | Read data, zero for reads that are not accepted |

## Verification
Each entry is preloaded with a distinct value, and every piece carries its own tag. A read that returns the wrong piece, the wrong entry or a stale value therefore cannot match the expected value by chance. Rejected reads (byte, misaligned, armed, secured, no source enabled) are inserted between accepted reads in the middle of an entry. The next accepted read then shows whether the rejected read moved the pointer. The lock is tested by arming, then disarming and trying malformed unlock writes, so an unlock that should not happen, or a lock that is released when armed falls, both show up. A full sweep of the buffer checks that the pointer wraps to entry 0, and a reset in the middle of the run checks that stored data survives reset.

// File: rtl/trwin_pkg.sv
package trwin_pkg;
    typedef enum logic [0:0] {
        LK_CLOSED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/trwin_qual.sv
module trwin_qual #(
    parameter int SRC_N = 2
) (
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_word,
    input  logic             bus_odd,
    input  logic             armed,
    input  logic             secured,
    input  logic [SRC_N-1:0] src_en,
    input  logic             is_open,
    output logic             rd_ok,
    output logic             unlock_ok
);
    logic aligned_word;

    always_comb begin
        aligned_word = bus_word && !bus_odd;
        rd_ok        = bus_rd && aligned_word && is_open && !secured
                       && !armed && (|src_en);
        unlock_ok    = bus_wr && aligned_word && !armed;
    end
endmodule

// File: rtl/trwin_lock_fsm.sv
module trwin_lock_fsm
    import trwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic unlock_ok,
    output logic is_open
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: begin
                if (!armed && unlock_ok) state_d = LK_OPEN;   // UNLOCK
            end
            LK_OPEN: begin
                if (armed) state_d = LK_CLOSED;               // ARM_LOCK
            end
            default: state_d = LK_CLOSED;
        endcase
    end

    always_comb begin
        is_open = (state_q == LK_OPEN);
    end
endmodule

// File: rtl/trwin_ptr.sv
module trwin_ptr #(
    parameter int DEPTH = 64,
    parameter int WPE   = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WW   = (WPE > 1) ? $clog2(WPE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          clr,
    output logic [AW-1:0] entry_q,
    output logic [WW-1:0] word_q
);
    localparam logic [AW-1:0] LAST_E = AW'(DEPTH - 1);
    localparam logic [WW-1:0] LAST_W = WW'(WPE - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
            word_q  <= '0;
        end else if (clr) begin
            entry_q <= '0;
            word_q  <= '0;
        end else if (adv) begin
            if (word_q == LAST_W) begin
                word_q  <= '0;
                entry_q <= (entry_q == LAST_E) ? '0 : entry_q + AW'(1);
            end else begin
                word_q  <= word_q + WW'(1);
            end
        end
    end
endmodule

// File: rtl/trwin_store.sv
module trwin_store #(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 64,
    parameter int BUS_W   = 16,
    localparam int WPE    = ENTRY_W / BUS_W,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WW     = (WPE > 1) ? $clog2(WPE) : 1
) (
    input  logic               clk,
    input  logic               tp_we,
    input  logic [AW-1:0]      tp_addr,
    input  logic [ENTRY_W-1:0] tp_data,
    input  logic [AW-1:0]      rd_entry,
    input  logic [WW-1:0]      rd_word,
    output logic [BUS_W-1:0]   word_out
);
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [ENTRY_W-1:0] cur;
    logic [BUS_W-1:0]   piece [WPE];

    always_ff @(posedge clk) begin
        if (tp_we) mem[tp_addr] <= tp_data;
    end

    assign cur = mem[rd_entry];

    for (genvar g = 0; g < WPE; g++) begin : g_piece
        assign piece[g] = cur[ENTRY_W-1-g*BUS_W -: BUS_W];
    end

    assign word_out = piece[rd_word];
endmodule

// File: rtl/trace_window.sv
module trace_window #(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 64,
    parameter int BUS_W   = 16,
    parameter int SRC_N   = 2,
    localparam int WPE    = ENTRY_W / BUS_W,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WW     = (WPE > 1) ? $clog2(WPE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_word,
    input  logic               bus_odd,
    input  logic               armed,
    input  logic               secured,
    input  logic [SRC_N-1:0]   src_en,
    input  logic               tp_we,
    input  logic [AW-1:0]      tp_addr,
    input  logic [ENTRY_W-1:0] tp_data,
    output logic [BUS_W-1:0]   rd_data
);
    logic          is_open;
    logic          rd_ok;
    logic          unlock_ok;
    logic [AW-1:0] ptr_entry;
    logic [WW-1:0] ptr_word;
    logic [BUS_W-1:0] sel_word;

    trwin_qual #(.SRC_N(SRC_N)) qual_i (
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_odd(bus_odd), .armed(armed), .secured(secured),
        .src_en(src_en), .is_open(is_open),
        .rd_ok(rd_ok), .unlock_ok(unlock_ok)
    );

    trwin_lock_fsm lock_i (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .unlock_ok(unlock_ok), .is_open(is_open)
    );

    trwin_ptr #(.DEPTH(DEPTH), .WPE(WPE)) ptr_i (
        .clk(clk), .rst_n(rst_n), .adv(rd_ok), .clr(unlock_ok),
        .entry_q(ptr_entry), .word_q(ptr_word)
    );

    trwin_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .BUS_W(BUS_W)) store_i (
        .clk(clk), .tp_we(tp_we), .tp_addr(tp_addr), .tp_data(tp_data),
        .rd_entry(ptr_entry), .rd_word(ptr_word), .word_out(sel_word)
    );

    assign rd_data = rd_ok ? sel_word : '0;
endmodule

// File: rtl/trwin_chk.sv
module trwin_chk #(
    parameter int AW    = 6,
    parameter int WW    = 2,
    parameter int BUS_W = 16,
    parameter int SRC_N = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_word,
    input logic             bus_odd,
    input logic             armed,
    input logic             secured,
    input logic [SRC_N-1:0] src_en,
    input logic             is_open,
    input logic [AW-1:0]    ptr_entry,
    input logic [WW-1:0]    ptr_word,
    input logic [BUS_W-1:0] rd_data
);
    assert_byte_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_word) |-> rd_data == '0);

    assert_odd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_odd) |-> rd_data == '0);

    assert_armed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> rd_data == '0);

    assert_arm_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> !is_open);

    assert_secure_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        secured |-> rd_data == '0);

    assert_nosrc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |-> rd_data == '0);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> ($stable(ptr_entry) && $stable(ptr_word)));

    assert_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word && !bus_odd && !armed)
        |=> (is_open && ptr_entry == '0 && ptr_word == '0));
endmodule

bind trace_window trwin_chk #(.AW(AW), .WW(WW), .BUS_W(BUS_W), .SRC_N(SRC_N)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_odd(bus_odd), .armed(armed),
    .secured(secured), .src_en(src_en), .is_open(is_open),
    .ptr_entry(ptr_entry), .ptr_word(ptr_word), .rd_data(rd_data)
);

// File: tb/trace_window_tb_top.sv
module trace_window_tb_top;
    localparam int DEPTH = 64;
    localparam int EW    = 64;
    localparam int BW    = 16;
    localparam int SN    = 2;
    localparam int WPE   = EW / BW;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0, bus_odd = 1'b0;
    logic          armed = 1'b0, secured = 1'b0;
    logic [SN-1:0] src_en = '0;
    logic          tp_we = 1'b0;
    logic [AW-1:0] tp_addr = '0;
    logic [EW-1:0] tp_data = '0;
    logic [BW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trace_window #(.DEPTH(DEPTH), .ENTRY_W(EW), .BUS_W(BW), .SRC_N(SN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_odd(bus_odd), .armed(armed),
        .secured(secured), .src_en(src_en), .tp_we(tp_we),
        .tp_addr(tp_addr), .tp_data(tp_data), .rd_data(rd_data)
    );

    function automatic logic [EW-1:0] pat(int e);
        return {16'h1000 + 16'(e), 16'h2000 + 16'(e), 16'h3000 + 16'(e), 16'h4000 + 16'(e)};
    endfunction

    function automatic logic [BW-1:0] exp_piece(int e, int w);
        logic [EW-1:0] v = pat(e);
        return v[EW-1-w*BW -: BW];
    endfunction

    task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic word, input logic odd, output logic [BW-1:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_word = word; bus_odd = odd;
        #2 v = rd_data;
        @(posedge clk);
        #1 bus_rd = 1'b0; bus_word = 1'b0; bus_odd = 1'b0;
    endtask

    task automatic wr(input logic word, input logic odd);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = word; bus_odd = odd;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_word = 1'b0; bus_odd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic preload();
        for (int e = 0; e < DEPTH; e++) begin
            @(negedge clk);
            tp_we = 1'b1; tp_addr = AW'(e); tp_data = pat(e);
        end
        @(negedge clk);
        tp_we = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [BW-1:0] v;
        rd(1'b1, 1'b0, v);
        check("R1 locked after reset", v, '0);
    endtask

    task automatic t_order();
        logic [BW-1:0] v;
        wr(1'b1, 1'b0);
        for (int i = 0; i < 2 * WPE; i++) begin
            rd(1'b1, 1'b0, v);
            check(i < WPE ? "R2 piece order" : "R3 next entry", v, exp_piece(i / WPE, i % WPE));
        end
    endtask

    task automatic t_rejects();
        logic [BW-1:0] v;
        wr(1'b1, 1'b0);
        rd(1'b1, 1'b0, v);
        check("R2 first piece", v, exp_piece(0, 0));
        rd(1'b0, 1'b0, v);
        check("R5 byte read zero", v, '0);
        rd(1'b1, 1'b1, v);
        check("R6 odd read zero", v, '0);
        secured = 1'b1;
        rd(1'b1, 1'b0, v);
        check("R8 secured zero", v, '0);
        secured = 1'b0;
        src_en = '0;
        rd(1'b1, 1'b0, v);
        check("R9 no source zero", v, '0);
        src_en = 2'b10;
        rd(1'b1, 1'b0, v);
        check("R5 R6 R8 R9 pointer held", v, exp_piece(0, 1));
        src_en = 2'b01;
    endtask

    task automatic t_lock();
        logic [BW-1:0] v;
        armed = 1'b1;
        rd(1'b1, 1'b0, v);
        check("R7 armed read zero", v, '0);
        wr(1'b1, 1'b0);
        armed = 1'b0;
        rd(1'b1, 1'b0, v);
        check("R11 armed write ignored", v, '0);
        wr(1'b0, 1'b0);
        rd(1'b1, 1'b0, v);
        check("R11 byte write ignored", v, '0);
        wr(1'b1, 1'b1);
        rd(1'b1, 1'b0, v);
        check("R11 odd write ignored", v, '0);
        check("R7 stays locked after disarm", v, '0);
        rd(1'b1, 1'b0, v);
        wr(1'b1, 1'b0);
        rd(1'b1, 1'b0, v);
        check("R10 unlock resets pointer", v, exp_piece(0, 0));
        rd(1'b1, 1'b0, v);
        check("R10 contents intact", v, exp_piece(0, 1));
    endtask

    task automatic t_wrap();
        logic [BW-1:0] v;
        wr(1'b1, 1'b0);
        for (int i = 0; i < DEPTH * WPE; i++) begin
            rd(1'b1, 1'b0, v);
            check("R3 sweep", v, exp_piece(i / WPE, i % WPE));
        end
        rd(1'b1, 1'b0, v);
        check("R4 wrap to entry 0", v, exp_piece(0, 0));
    endtask

    task automatic t_keep();
        logic [BW-1:0] v;
        do_reset();
        rd(1'b1, 1'b0, v);
        check("R12 locked after reset", v, '0);
        wr(1'b1, 1'b0);
        rd(1'b1, 1'b0, v);
        check("R12 data kept", v, exp_piece(0, 0));
        rd(1'b1, 1'b0, v);
        check("R12 data kept piece 1", v, exp_piece(0, 1));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        src_en = 2'b01;
        preload();
        rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_order();
        t_rejects();
        t_lock();
        t_wrap();
        t_keep();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule